// File: doc/BRIEF.md
# Grouped Message-Interrupt Vector Aggregator

This block receives message-signalled interrupt writes, each carrying a vector number from 0 to 31. It folds them into eight interrupt lines for a host processor. Vectors are spread across the groups by their value modulo 8, so group g collects vectors g, g+8, g+16 and g+24. Each group keeps a 4-bit pending register and one interrupt output.

Vector writes reach the block on two paths. The first is a valid/ready message stream. The block never applies back-pressure on it: `msi_ready` is low while reset is asserted and from then on stays high one cycle after reset is released. The second path is a trigger register on a plain host register bus.

The host clears an interrupt in two steps. It first clears pending bits by writing ones to the group's status register. It then writes the group's interrupt number to the end-of-interrupt register, which re-arms the group so that it can fire again. A group whose interrupt is pending cannot produce a second pulse until it has been re-armed.

Host register map (word addresses on `reg_addr`): 0 is the trigger register, 1 is the end-of-interrupt register, and 2+g is the status register of group g.

Top module: `msi_vector_aggregator`

## Requirements
- R1: After reset every status register reads zero, every `irq_o` bit is low and every group is armed, so the first vector that lands in any group produces a pulse.
- R2: A vector write with value V (on the stream or at address 0) sets bit V[4:3] of the status register of group V[2:0]. Bits 31 to 5 of the written value are ignored.
- R3: A read at address 2+g returns group g's status in bits 3:0, where bit k stands for vector 8k+g. Bits 31 to 4 read as zero.
- R4: A host write to address 2+g clears each status bit whose data bit is 1. Status bits whose data bit is 0 keep their value.
- R5: Reads at address 0 (trigger) and address 1 (end-of-interrupt) return all zeros.
- R6: When an armed group has nonzero status, its `irq_o` bit is high for exactly one cycle. That cycle is the second cycle after the clock edge that accepted the vector. The group is then disarmed, and later vectors for it produce no pulse.
- R7: A write of 4+g to address 1 re-arms group g. If that group's status is still nonzero at that point, it pulses again with the same two-edge latency.
- R8: An end-of-interrupt write whose full 32-bit value is outside 4 to 11 affects no group.
- R9: If a vector write sets a status bit in the same cycle that a host write clears it, the bit ends up set.
- R10: `msi_ready` is low during reset and high from the first cycle after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| msi_valid | input | 1 | Message vector write present |
| msi_ready | output | 1 | Block accepts a message this cycle |
| msi_data | input | 32 | Message data; bits 4:0 are the vector |
| reg_wr | input | 1 | Host register write strobe |
| reg_rd | input | 1 | Host register read strobe |
| reg_addr | input | 4 | Host register word address |
| reg_wdata | input | 32 | Host write data |
| reg_rdata | output | 32 | Host read data, combinational, zero when not reading |
| irq_o | output | 8 | Per-group interrupt pulses |

## Verification
The hardest situations to reach are a set and a clear hitting the same status bit in one cycle, and a re-arm arriving while a group still has pending bits. Both need two sources to act together, or need a precise order of host writes after a pulse. The stimulus sends every one of the 32 vectors in turn. It alternates between the stream and the host bus, and each vector carries junk in its upper bits. After the group fires, a second vector of the same group is sent so that the group is disarmed with two pending bits. One bit is cleared, and then the re-arm is issued so that the remaining pending bit has to cause a second pulse. A final step drives a stream vector and a host clear of the same bit in the same cycle.

// File: rtl/msi_agg_pkg.sv
package msi_agg_pkg;

  // Host register word addresses
  localparam int unsigned ADDR_TRIG  = 0;
  localparam int unsigned ADDR_EOI   = 1;
  localparam int unsigned ADDR_STAT0 = 2;

  // Interrupt number carried by the end-of-interrupt write for group 0
  localparam int unsigned EOI_BASE = 4;

  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_TRIG = 2'd1,
    ACC_EOI  = 2'd2,
    ACC_STAT = 2'd3
  } acc_kind_e;

endpackage

// File: rtl/msi_reg_decode.sv
module msi_reg_decode
  import msi_agg_pkg::*;
#(
  parameter int unsigned NUM_GROUPS = 8,
  parameter int unsigned VEC_PER_GRP = 4,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned VEC_W = $clog2(NUM_GROUPS * VEC_PER_GRP),
  localparam int unsigned FLAT_W = NUM_GROUPS * VEC_PER_GRP
) (
  input  logic                  wr_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [DATA_W-1:0]     wdata_i,
  output logic                  trig_valid_o,
  output logic [VEC_W-1:0]      trig_vec_o,
  output logic [NUM_GROUPS-1:0] eoi_hit_o,
  output logic [FLAT_W-1:0]     clr_flat_o
);

  acc_kind_e kind;

  // Classify the host access by address
  always_comb begin
    kind = ACC_NONE;
    if (wr_i) begin
      if (addr_i == ADDR_W'(ADDR_TRIG)) begin
        kind = ACC_TRIG;
      end else if (addr_i == ADDR_W'(ADDR_EOI)) begin
        kind = ACC_EOI;
      end else if ((int'(addr_i) >= ADDR_STAT0) &&
                   (int'(addr_i) < ADDR_STAT0 + NUM_GROUPS)) begin
        kind = ACC_STAT;
      end
    end
  end

  assign trig_valid_o = (kind == ACC_TRIG);
  assign trig_vec_o   = wdata_i[VEC_W-1:0];

  // Per-group re-arm and write-one-to-clear strobes
  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    assign eoi_hit_o[g] = (kind == ACC_EOI) &&
                          (wdata_i == DATA_W'(EOI_BASE + g));
    assign clr_flat_o[g*VEC_PER_GRP +: VEC_PER_GRP] =
        ((kind == ACC_STAT) && (addr_i == ADDR_W'(ADDR_STAT0 + g)))
          ? wdata_i[VEC_PER_GRP-1:0] : '0;
  end

endmodule

// File: rtl/msi_vec_decode.sv
module msi_vec_decode #(
  parameter int unsigned NUM_GROUPS = 8,
  parameter int unsigned VEC_PER_GRP = 4,
  parameter int unsigned NUM_SRC = 2,
  localparam int unsigned VEC_W = $clog2(NUM_GROUPS * VEC_PER_GRP),
  localparam int unsigned FLAT_W = NUM_GROUPS * VEC_PER_GRP
) (
  input  logic [NUM_SRC-1:0]       src_valid_i,
  input  logic [NUM_SRC*VEC_W-1:0] src_vec_i,
  output logic [FLAT_W-1:0]        set_flat_o
);

  // Flat bit g*VEC_PER_GRP+k stands for vector k*NUM_GROUPS+g
  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    for (genvar k = 0; k < VEC_PER_GRP; k++) begin : g_bit
      logic [NUM_SRC-1:0] hit;
      for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        assign hit[s] = src_valid_i[s] &&
            (src_vec_i[s*VEC_W +: VEC_W] == VEC_W'(k * NUM_GROUPS + g));
      end
      assign set_flat_o[g*VEC_PER_GRP + k] = |hit;
    end
  end

endmodule

// File: rtl/msi_group_slice.sv
module msi_group_slice #(
  parameter int unsigned VEC_PER_GRP = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [VEC_PER_GRP-1:0] set_i,
  input  logic [VEC_PER_GRP-1:0] clr_i,
  input  logic                   eoi_i,
  output logic [VEC_PER_GRP-1:0] status_o,
  output logic                   irq_o
);

  logic [VEC_PER_GRP-1:0] st_q;
  logic armed_q;
  logic irq_q;
  logic fire;

  assign fire = armed_q && (st_q != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= '0;
      armed_q <= 1'b1;
      irq_q   <= 1'b0;
    end else begin
      // A new set wins over a clear of the same bit
      st_q    <= (st_q & ~clr_i) | set_i;
      // Firing disarms; a re-arm in the firing cycle is dropped
      armed_q <= fire ? 1'b0 : (armed_q | eoi_i);
      irq_q   <= fire;
    end
  end

  assign status_o = st_q;
  assign irq_o    = irq_q;

endmodule

// File: rtl/msi_status_readmux.sv
module msi_status_readmux
  import msi_agg_pkg::*;
#(
  parameter int unsigned NUM_GROUPS = 8,
  parameter int unsigned VEC_PER_GRP = 4,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned FLAT_W = NUM_GROUPS * VEC_PER_GRP
) (
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [FLAT_W-1:0] status_flat_i,
  output logic [DATA_W-1:0] rdata_o
);

  logic [NUM_GROUPS-1:0]   sel;
  logic [VEC_PER_GRP-1:0]  picked;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_sel
    assign sel[g] = rd_i && (addr_i == ADDR_W'(ADDR_STAT0 + g));
  end

  // Trigger and end-of-interrupt addresses never select a group, so read zero
  always_comb begin
    picked = '0;
    for (int g = 0; g < NUM_GROUPS; g++) begin
      if (sel[g]) picked = picked | status_flat_i[g*VEC_PER_GRP +: VEC_PER_GRP];
    end
    rdata_o = DATA_W'(picked);
  end

endmodule

// File: rtl/msi_vector_aggregator.sv
module msi_vector_aggregator #(
  parameter int unsigned NUM_GROUPS = 8,
  parameter int unsigned VEC_PER_GRP = 4,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  msi_valid,
  output logic                  msi_ready,
  input  logic [DATA_W-1:0]     msi_data,
  input  logic                  reg_wr,
  input  logic                  reg_rd,
  input  logic [ADDR_W-1:0]     reg_addr,
  input  logic [DATA_W-1:0]     reg_wdata,
  output logic [DATA_W-1:0]     reg_rdata,
  output logic [NUM_GROUPS-1:0] irq_o
);

  localparam int unsigned VEC_W  = $clog2(NUM_GROUPS * VEC_PER_GRP);
  localparam int unsigned FLAT_W = NUM_GROUPS * VEC_PER_GRP;
  localparam int unsigned NUM_SRC = 2;

  logic                  rdy_q;
  logic                  host_trig;
  logic [VEC_W-1:0]      host_vec;
  logic [NUM_GROUPS-1:0] eoi_hit;
  logic [FLAT_W-1:0]     clr_flat;
  logic [FLAT_W-1:0]     set_flat;
  logic [FLAT_W-1:0]     status_flat;

  always_ff @(posedge clk) begin
    if (!rst_n) rdy_q <= 1'b0;
    else        rdy_q <= 1'b1;
  end
  assign msi_ready = rdy_q;

  msi_reg_decode #(
    .NUM_GROUPS(NUM_GROUPS), .VEC_PER_GRP(VEC_PER_GRP),
    .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) dec_i (
    .wr_i(reg_wr), .addr_i(reg_addr), .wdata_i(reg_wdata),
    .trig_valid_o(host_trig), .trig_vec_o(host_vec),
    .eoi_hit_o(eoi_hit), .clr_flat_o(clr_flat)
  );

  msi_vec_decode #(
    .NUM_GROUPS(NUM_GROUPS), .VEC_PER_GRP(VEC_PER_GRP), .NUM_SRC(NUM_SRC)
  ) vdec_i (
    .src_valid_i({host_trig, msi_valid && rdy_q}),
    .src_vec_i({host_vec, msi_data[VEC_W-1:0]}),
    .set_flat_o(set_flat)
  );

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_slice
    msi_group_slice #(.VEC_PER_GRP(VEC_PER_GRP)) slice_i (
      .clk(clk), .rst_n(rst_n),
      .set_i(set_flat[g*VEC_PER_GRP +: VEC_PER_GRP]),
      .clr_i(clr_flat[g*VEC_PER_GRP +: VEC_PER_GRP]),
      .eoi_i(eoi_hit[g]),
      .status_o(status_flat[g*VEC_PER_GRP +: VEC_PER_GRP]),
      .irq_o(irq_o[g])
    );
  end

  msi_status_readmux #(
    .NUM_GROUPS(NUM_GROUPS), .VEC_PER_GRP(VEC_PER_GRP),
    .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) rmux_i (
    .rd_i(reg_rd), .addr_i(reg_addr),
    .status_flat_i(status_flat), .rdata_o(reg_rdata)
  );

endmodule

// File: rtl/msi_agg_checker.sv
module msi_agg_checker
  import msi_agg_pkg::*;
#(
  parameter int unsigned NUM_GROUPS = 8,
  parameter int unsigned VEC_PER_GRP = 4,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned VEC_W = $clog2(NUM_GROUPS * VEC_PER_GRP),
  localparam int unsigned GRP_W = $clog2(NUM_GROUPS),
  localparam int unsigned FLAT_W = NUM_GROUPS * VEC_PER_GRP
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  msi_valid,
  input logic                  msi_ready,
  input logic [DATA_W-1:0]     msi_data,
  input logic                  reg_wr,
  input logic                  reg_rd,
  input logic [ADDR_W-1:0]     reg_addr,
  input logic [DATA_W-1:0]     reg_wdata,
  input logic [DATA_W-1:0]     reg_rdata,
  input logic [NUM_GROUPS-1:0] irq_o,
  input logic [FLAT_W-1:0]     status_flat
);

  function automatic int unsigned flat_idx(input logic [VEC_W-1:0] v);
    return int'(v[GRP_W-1:0]) * VEC_PER_GRP + int'(v[VEC_W-1:GRP_W]);
  endfunction

  logic             strm_seen_q, host_seen_q, host_wr_q;
  logic [VEC_W-1:0] strm_vec_q, host_vec_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      strm_seen_q <= 1'b0;
      host_seen_q <= 1'b0;
      host_wr_q   <= 1'b0;
      strm_vec_q  <= '0;
      host_vec_q  <= '0;
    end else begin
      strm_seen_q <= msi_valid && msi_ready;
      strm_vec_q  <= msi_data[VEC_W-1:0];
      host_seen_q <= reg_wr && (reg_addr == ADDR_W'(ADDR_TRIG));
      host_vec_q  <= reg_wdata[VEC_W-1:0];
      host_wr_q   <= reg_wr;
    end
  end

  AST_STREAM_SETS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    strm_seen_q |-> status_flat[flat_idx(strm_vec_q)]);  // R2

  AST_HOST_SETS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    host_seen_q |-> status_flat[flat_idx(host_vec_q)]);  // R9

  AST_NO_CLEAR_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !host_wr_q |-> ((~status_flat & $past(status_flat)) == '0));  // R4

  AST_CTRL_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && (reg_addr == ADDR_W'(ADDR_TRIG) || reg_addr == ADDR_W'(ADDR_EOI)))
      |-> (reg_rdata == '0));  // R5

  AST_READY_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> msi_ready);  // R10

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_irq
    AST_IRQ_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o[g] |=> !irq_o[g]);  // R6
    AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o[g] |-> ($past(status_flat[g*VEC_PER_GRP +: VEC_PER_GRP]) != '0));  // R7
  end

endmodule

bind msi_vector_aggregator msi_agg_checker #(
  .NUM_GROUPS(NUM_GROUPS), .VEC_PER_GRP(VEC_PER_GRP),
  .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) chk_i (
  .clk(clk), .rst_n(rst_n),
  .msi_valid(msi_valid), .msi_ready(msi_ready), .msi_data(msi_data),
  .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
  .irq_o(irq_o), .status_flat(status_flat)
);

// File: tb/msi_vector_aggregator_tb.sv
module msi_vector_aggregator_tb_top;

  localparam int NG = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        msi_valid = 1'b0;
  logic        msi_ready;
  logic [31:0] msi_data = '0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [7:0]  irq_o;

  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  msi_vector_aggregator dut_i (
    .clk(clk), .rst_n(rst_n),
    .msi_valid(msi_valid), .msi_ready(msi_ready), .msi_data(msi_data),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic host_wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic stream_wr(input logic [31:0] d);
    @(negedge clk);
    msi_valid = 1'b1; msi_data = d;
    @(negedge clk);
    msi_valid = 1'b0;
  endtask

  task automatic host_rd(input logic [3:0] a, output logic [31:0] d);
    reg_rd = 1'b1; reg_addr = a;
    #1;
    d = reg_rdata;
    reg_rd = 1'b0;
  endtask

  // Called right after a write task returns: irq low now, pulse next, low after
  task automatic watch_irq(input string tag, input logic [7:0] exp);
    chk({tag, " pre"}, 32'(irq_o), 32'h0);
    @(negedge clk);
    chk({tag, " pulse"}, 32'(irq_o), 32'(exp));
    @(negedge clk);
    chk({tag, " post"}, 32'(irq_o), 32'h0);
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    chk("R10 ready low in reset", 32'(msi_ready), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 ready after reset", 32'(msi_ready), 32'h1);
    chk("R1 irq idle", 32'(irq_o), 32'h0);
    for (int g = 0; g < NG; g++) begin
      host_rd(4'(2 + g), rd);
      chk("R1 status zero", rd, 32'h0);
    end

    // Sweep every vector
    for (int v = 0; v < 32; v++) begin
      int g, b, v2, b2;
      logic [31:0] junk;
      g = v % 8; b = v / 8; v2 = (v + 8) % 32; b2 = v2 / 8;
      junk = 32'(v * 37 + 5) << 5;
      if (v % 2 == 0) host_wr(4'd0, junk | 32'(v));
      else            stream_wr(junk | 32'(v));
      watch_irq("R6 R1 first pulse", 8'(1 << g));
      for (int gg = 0; gg < NG; gg++) begin
        host_rd(4'(2 + gg), rd);
        chk("R2 R3 status after vector", rd, (gg == g) ? 32'(1 << b) : 32'h0);
      end
      if (v == 0) begin
        host_rd(4'd0, rd); chk("R5 trigger reads zero", rd, 32'h0);
        host_rd(4'd1, rd); chk("R5 eoi reads zero", rd, 32'h0);
      end
      // Second vector of same group: disarmed, no pulse
      if (v % 2 == 0) stream_wr(junk | 32'(v2));
      else            host_wr(4'd0, junk | 32'(v2));
      watch_irq("R6 disarmed no pulse", 8'h0);
      host_rd(4'(2 + g), rd);
      chk("R2 two pending bits", rd, 32'((1 << b) | (1 << b2)));
      // Out-of-range re-arm numbers
      host_wr(4'd1, 32'd3);
      watch_irq("R8 eoi 3 ignored", 8'h0);
      host_wr(4'd1, 32'd12);
      watch_irq("R8 eoi 12 ignored", 8'h0);
      host_wr(4'd1, 32'h100 + 32'(4 + g));
      watch_irq("R8 eoi upper bits ignored", 8'h0);
      // Clear one bit only
      host_wr(4'(2 + g), 32'(1 << b));
      host_rd(4'(2 + g), rd);
      chk("R4 w1c one bit", rd, 32'(1 << b2));
      // Re-arm with status pending: pulses again
      host_wr(4'd1, 32'(4 + g));
      watch_irq("R7 rearm pending pulse", 8'(1 << g));
      host_wr(4'(2 + g), 32'(1 << b2));
      host_rd(4'(2 + g), rd);
      chk("R4 w1c last bit", rd, 32'h0);
      host_wr(4'd1, 32'(4 + g));
      watch_irq("R7 rearm empty no pulse", 8'h0);
    end

    // Same-cycle set and clear of one bit
    stream_wr(32'd5);
    watch_irq("R6 group5 pulse", 8'h20);
    @(negedge clk);
    msi_valid = 1'b1; msi_data = 32'd13;
    reg_wr = 1'b1; reg_addr = 4'd7; reg_wdata = 32'hF;
    @(negedge clk);
    msi_valid = 1'b0; reg_wr = 1'b0;
    host_rd(4'd7, rd);
    chk("R9 set wins over clear", rd, 32'h2);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule